// File: doc/BRIEF.md
# Multichannel Pulse Event Counter

This block counts digitized detector pulses on a bank of independent input channels. Each channel carries fixed-width logic pulses from a discriminator. Every input is brought into the clock domain through two flops. A pulse is accepted only once it has stayed high for a programmable minimum number of clock cycles. At 100 MHz a minimum of 5 cycles admits 50 ns pulses, and 70 ns pulses pass with margin. Each accepted pulse adds one to that channel's running count, and the counts are held in on-chip storage.

Accepted pulses first land in a small per-channel pending counter. A scan engine visits one channel per clock. On each visit it adds the pending value to the stored count, saturating at all-ones. A host processor reads any channel's count through a synchronous read port with a fixed one-cycle latency, and it can zero the channel in the same access. Counting never pauses for host reads. An increment that meets a clearing read on the same channel in the same cycle is kept.

Top module: `pulse_count_bank`

## Requirements
- R1: After reset every channel count reads as zero and `rd_valid` is low.
- R2: A pulse that stays high for at least the effective minimum width adds exactly one to its channel, however long it lasts.
- R3: A pulse shorter than the effective minimum width leaves its channel count unchanged.
- R4: A `min_width` value of 0 acts as a minimum width of 1 cycle.
- R5: Pulses on one channel never change the count of any other channel, including pulses on several channels at once.
- R6: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high. `rd_data` then holds the count of channel `rd_addr` as it stood when the read was issued.
- R7: A read with `rd_clear` high returns the count as it stood before the read and leaves the channel at zero.
- R8: A channel count saturates at all-ones and never wraps.
- R9: Accepted pulses are never lost while the host reads, even when clearing reads hit the channel every cycle. The values returned by the reads plus the residual count equal the number of accepted pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | NCH | Discriminator pulse per channel, asynchronous |
| min_width | input | WW | Minimum accepted high time in cycles (0 acts as 1) |
| rd_en | input | 1 | Host read request |
| rd_addr | input | $clog2(NCH) | Channel number to read |
| rd_clear | input | 1 | Zero the channel as part of this read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | CW | Count of the channel that was read |

## Verification
The hardest case to produce from the ports is a clearing read and the scan engine's write-back landing on the same channel in the same cycle, while a pulse is still waiting in that channel's pending counter. The bench creates it with a train of pulses on one channel while it issues back-to-back clearing reads of that channel for more than a full scan period. That makes the collision certain, whatever the scan phase. It then checks that the sum of all returned values equals the pulse count. Saturation is reached by running the bench with a narrow count width and sending more pulses than the count can hold.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int unsigned SAT_W = 64;

    typedef logic [SAT_W-1:0] wide_t;

    // Saturating add: result is clamped to lim
    function automatic wide_t sat_add(input wide_t a, input wide_t b, input wide_t lim);
        wide_t s;
        s = a + b;
        if ((s > lim) || (s < a)) begin
            return lim;
        end
        return s;
    endfunction

    typedef struct packed {
        logic en;
        logic clear;
    } rd_ctl_t;

endpackage

// File: rtl/pcb_chan_qual.sv
module pcb_chan_qual #(
    parameter int unsigned WW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_raw,
    input  logic [WW-1:0] min_width,
    output logic          hit
);
    localparam logic [WW-1:0] RUN_MAX = {WW{1'b1}};

    logic          s1, s2;
    logic [WW-1:0] run_len;
    logic [WW-1:0] min_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= pulse_raw;
            s2 <= s1;
        end
    end

    // Counts high cycles already seen in the current pulse
    always_ff @(posedge clk) begin
        if (rst || !s2) begin
            run_len <= '0;
        end else if (run_len != RUN_MAX) begin
            run_len <= run_len + 1'b1;
        end
    end

    assign min_eff = (min_width == '0) ? WW'(1) : min_width;
    assign hit     = s2 && (run_len == (min_eff - 1'b1));

endmodule

// File: rtl/pcb_pend.sv
module pcb_pend #(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          svc,
    output logic [PW-1:0] pend
);
    localparam logic [PW-1:0] PEND_MAX = {PW{1'b1}};

    logic [PW-1:0] base;

    assign base = svc ? '0 : pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (hit && (base != PEND_MAX)) begin
            pend <= base + 1'b1;
        end else begin
            pend <= base;
        end
    end

endmodule

// File: rtl/pcb_count_store.sv
module pcb_count_store
    import pcb_pkg::*;
#(
    parameter int unsigned NCH = 64,
    parameter int unsigned CW  = 32,
    parameter int unsigned PW  = 4,
    localparam int unsigned AW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] scan_add,
    output logic [AW-1:0] scan_ptr,
    output logic [CW-1:0] scan_old,
    output logic [CW-1:0] scan_new,
    input  rd_ctl_t       rd_ctl,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [CW-1:0] rd_data
);
    localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
    localparam logic [AW-1:0] PTR_LAST = AW'(NCH - 1);

    logic [CW-1:0] mem [NCH];

    assign scan_old = mem[scan_ptr];
    assign scan_new = CW'(sat_add(wide_t'(scan_old), wide_t'(scan_add), wide_t'(CNT_MAX)));

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_ptr <= '0;
            for (int i = 0; i < NCH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            scan_ptr      <= (scan_ptr == PTR_LAST) ? '0 : scan_ptr + 1'b1;
            mem[scan_ptr] <= scan_new;
            // A clear on the channel under scan keeps that cycle's pending add
            if (rd_ctl.en && rd_ctl.clear) begin
                mem[rd_addr] <= (rd_addr == scan_ptr) ? CW'(scan_add) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_ctl.en;
            if (rd_ctl.en) begin
                rd_data <= mem[rd_addr];
            end
        end
    end

endmodule

// File: rtl/pulse_count_bank.sv
module pulse_count_bank
    import pcb_pkg::*;
#(
    parameter int unsigned NCH = 64,
    parameter int unsigned CW  = 32,
    parameter int unsigned WW  = 8,
    parameter int unsigned PW  = 4,
    localparam int unsigned AW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pulse_in,
    input  logic [WW-1:0]  min_width,
    input  logic           rd_en,
    input  logic [AW-1:0]  rd_addr,
    input  logic           rd_clear,
    output logic           rd_valid,
    output logic [CW-1:0]  rd_data
);
    logic [NCH-1:0] hits;
    logic [PW-1:0]  pend_arr [NCH];
    logic [AW-1:0]  scan_ptr;
    logic [CW-1:0]  scan_old;
    logic [CW-1:0]  scan_new;
    logic [PW-1:0]  scan_add;
    rd_ctl_t        rd_ctl;

    assign rd_ctl.en    = rd_en;
    assign rd_ctl.clear = rd_clear;
    assign scan_add     = pend_arr[scan_ptr];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pcb_chan_qual #(.WW(WW)) u_qual (
            .clk       (clk),
            .rst       (rst),
            .pulse_raw (pulse_in[g]),
            .min_width (min_width),
            .hit       (hits[g])
        );
        pcb_pend #(.PW(PW)) u_pend (
            .clk  (clk),
            .rst  (rst),
            .hit  (hits[g]),
            .svc  (scan_ptr == AW'(g)),
            .pend (pend_arr[g])
        );
    end

    pcb_count_store #(.NCH(NCH), .CW(CW), .PW(PW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .scan_add (scan_add),
        .scan_ptr (scan_ptr),
        .scan_old (scan_old),
        .scan_new (scan_new),
        .rd_ctl   (rd_ctl),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int unsigned NCH = 64,
    parameter int unsigned CW  = 32,
    localparam int unsigned AW = $clog2(NCH)
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          rd_valid,
    input logic [AW-1:0] scan_ptr,
    input logic [CW-1:0] scan_old,
    input logic [CW-1:0] scan_new
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rd_valid); // R1

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R6

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (armed && !rd_en) |=> !rd_valid); // R6

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        armed |-> (scan_new >= scan_old)); // R8

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed && (scan_old == {CW{1'b1}})) |-> (scan_new == {CW{1'b1}})); // R8

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        armed |=> (scan_ptr == (($past(scan_ptr) == AW'(NCH - 1)) ? '0 : $past(scan_ptr) + 1'b1))); // R9

endmodule

bind pulse_count_bank pcb_checker #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .scan_ptr (scan_ptr),
    .scan_old (scan_old),
    .scan_new (scan_new)
);

// File: tb/sim_pulse_count_bank.sv
module sim_pulse_count_bank;
    localparam int NCH = 64;
    localparam int CW  = 8;
    localparam int WW  = 8;
    localparam int AW  = $clog2(NCH);
    localparam int CLK_PERIOD = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] pulse_in = '0;
    logic [WW-1:0]  min_width = '0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic           rd_clear = 1'b0;
    logic           rd_valid;
    logic [CW-1:0]  rd_data;

    int    checks = 0;
    int    errors = 0;
    int    exp_cnt [NCH];
    int    exp_q [$];
    string tag_q [$];
    bit    accum = 1'b0;
    int    acc_sum = 0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_count_bank #(.NCH(NCH), .CW(CW), .WW(WW)) u0 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .min_width(min_width),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_clear(rd_clear),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [NCH-1:0] m, input int len, input int gap);
        int eff;
        eff = (min_width == 0) ? 1 : int'(min_width);
        @(negedge clk);
        pulse_in = m;
        repeat (len) @(negedge clk);
        pulse_in = '0;
        repeat (gap - 1) @(negedge clk);
        if (len >= eff) begin
            for (int i = 0; i < NCH; i++) begin
                if (m[i] && exp_cnt[i] < CMAX) exp_cnt[i]++;
            end
        end
    endtask

    task automatic rd(input int ch, input bit clr, input string req);
        @(negedge clk);
        rd_en    = 1'b1;
        rd_addr  = AW'(ch);
        rd_clear = clr;
        exp_q.push_back(exp_cnt[ch]);
        tag_q.push_back(req);
        if (clr) exp_cnt[ch] = 0;
    endtask

    task automatic rd_idle();
        @(negedge clk);
        rd_en    = 1'b0;
        rd_clear = 1'b0;
    endtask

    task automatic settle();
        repeat (NCH + 8) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6 actual rd_valid 1 expected 0");
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (accum) acc_sum += int'(rd_data);
                else check(t, int'(rd_data), e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) exp_cnt[i] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(rd_valid), 0);

        // R1: all counts zero after reset
        for (int i = 0; i < NCH; i++) rd(i, 1'b0, "R1");
        rd_idle();

        // R2 / R3: qualification against minimum of 5
        min_width = 8'd5;
        pulse(NCH'(1) << 3, 7, 4);
        pulse(NCH'(1) << 3, 5, 4);
        pulse(NCH'(1) << 3, 4, 4);
        pulse(NCH'(1) << 3, 20, 4);
        pulse(NCH'(1) << 10, 2, 4);
        pulse(NCH'(1) << 10, 4, 4);
        settle();
        rd(3, 1'b0, "R2");
        rd(10, 1'b0, "R3");
        rd_idle();

        // R6: explicit latency check
        rd(3, 1'b0, "R6");
        @(negedge clk);
        check("R6", int'(rd_valid), 1);
        rd_en = 1'b0;
        @(negedge clk);
        check("R6", int'(rd_valid), 0);

        // R5: several channels at once
        for (int k = 0; k < 3; k++) pulse((NCH'(1) << 0) | (NCH'(1) << 63) | (NCH'(1) << 20), 6, 3);
        settle();
        rd(0, 1'b0, "R5");
        rd(63, 1'b0, "R5");
        rd(20, 1'b0, "R5");
        rd(21, 1'b0, "R5");
        rd(3, 1'b0, "R5");
        rd_idle();

        // R4: zero minimum behaves as one
        min_width = 8'd0;
        pulse(NCH'(1) << 5, 1, 4);
        settle();
        rd(5, 1'b0, "R4");
        rd_idle();

        // R7: clear-on-read
        rd(3, 1'b1, "R7");
        rd_idle();
        rd(3, 1'b0, "R7");
        rd_idle();

        // R8: saturation with more pulses than the count holds
        min_width = 8'd1;
        for (int k = 0; k < CMAX + 5; k++) pulse(NCH'(1) << 7, 1, 8);
        settle();
        rd(7, 1'b0, "R8");
        rd_idle();
        check("R8", exp_cnt[7], CMAX);

        // R9: clearing reads every cycle while pulses arrive
        @(negedge clk);
        accum = 1'b1;
        fork
            begin
                for (int k = 0; k < 40; k++) pulse(NCH'(1) << 9, 2, 6);
            end
            begin
                repeat (400 + NCH) rd(9, 1'b1, "R9");
                rd_idle();
            end
        join
        repeat (3) @(negedge clk);
        accum = 1'b0;
        exp_cnt[9] = 0;
        settle();
        rd(9, 1'b0, "R9");
        rd_idle();
        repeat (3) @(negedge clk);
        check("R9", acc_sum, 40);
        check("R9", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule